// File: doc/BRIEF.md
# Content-Directed Pointer Prefetcher

This block sits beside a first-level data cache and looks inside each 64-byte line as it is filled. It reads the line as eight 64-bit words. Any word whose value could be a virtual address in a configured window is turned into a prefetch request for the cache line that the value points to. The next prefetch address therefore comes from the data being loaded, not from the stream of load addresses.

Each line index has one suppression bit. When a fill of a line starts a scan, that bit is set, and later fills of the same index are taken without a scan. Only an eviction notice that says the line has left both cache levels clears the bit. A small direct-mapped table of recently requested line addresses removes repeat requests. Requests wait in a short FIFO and leave through a valid/ready port. When the FIFO is full, the candidate is discarded and a saturating counter goes up by one.

Top module: `dmp_prefetcher`

## Requirements
- R1: A fill is scanned whatever its source (`fill_src` 0 = second-level cache, 1 = DRAM), provided that source's bit in `SRC_MASK` is set. By default both bits are set.
- R2: A word is pointer-like only when all of its bits at and above `VA_W` are zero, it is non-zero, and `WIN_LO <= word < WIN_HI`.
- R3: Word k of a line sits at `fill_data[64k+63:64k]`. The words are examined one per cycle, from k = 0 up to k = 7. Each request that is issued carries the word's value with bits [5:0] cleared, and requests leave in the order they were issued.
- R4: A fill that starts a scan holds `fill_ready` low for exactly 8 cycles. A fill offered during that time waits until `fill_ready` returns high.
- R5: A scan starts only on a fill that is accepted, whose index has a clear suppression bit, and which holds at least one pointer-like word. That scan sets the index's bit. A fill whose bit is already set is accepted with no scan and no request.
- R6: An eviction notice with `evict_both` = 1 clears the bit of `evict_idx`. A notice with `evict_both` = 0 has no effect.
- R7: A candidate whose line address equals the tag held in its direct-mapped history slot (slot = line address mod `HIST_N`) is suppressed. Each issued request writes its line address into that slot, and the write is visible to the next word.
- R8: A candidate that is not suppressed is discarded when the FIFO holds `FIFO_D` entries at the start of the cycle. Each discard raises `drop_cnt` by one, and the counter saturates.
- R9: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_addr` stay unchanged.
- R10: After reset, every suppression bit and history slot is clear, the FIFO is empty, `drop_cnt` is 0 and `fill_ready` is 1.
- R11: When a scan start and a both-level eviction name the same index in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | A line fill is offered |
| fill_ready | output | 1 | The block can take a fill |
| fill_idx | input | IDX_W | Cache line index of the fill |
| fill_src | input | 1 | Fill source: 0 second-level cache, 1 DRAM |
| fill_data | input | 512 | Line contents, word k at bits [64k+63:64k] |
| evict_valid | input | 1 | An eviction notice is present |
| evict_idx | input | IDX_W | Line index that was evicted |
| evict_both | input | 1 | The line has left both cache levels |
| pf_valid | output | 1 | A prefetch request is available |
| pf_ready | input | 1 | The consumer takes the request |
| pf_addr | output | VA_W | Line-aligned prefetch address |
| drop_cnt | output | CNT_W | Saturating count of discarded candidates |

## Verification
The bound checker checks these properties on every cycle:
- A scan keeps `fill_ready` low for exactly eight sampled cycles.
- A fill to a suppressed index never lowers `fill_ready`.
- A scan start leaves its index's bit set.
- A both-level eviction clears its bit.
- A stalled request stays stable.
- Every issued address is line-aligned and below the window top.
- The discard counter moves by at most one per cycle.

The bench's scenarios alone can show the following:
- Which words turn into requests, and in what order.
- That the history table suppresses repeats and is replaced on a slot collision.
- That a full FIFO discards exactly the surplus.
- That a set-and-clear in the same cycle leaves the line suppressed.

// File: rtl/dmp_pkg.sv
`timescale 1ns/1ps
package dmp_pkg;

    localparam int WORD_W     = 64;
    localparam int LINE_WORDS = 8;
    localparam int OFF_W      = 6;
    localparam int LINE_W     = WORD_W * LINE_WORDS;

    typedef enum logic {
        SRC_L2   = 1'b0,
        SRC_DRAM = 1'b1
    } fill_src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;

    typedef logic [LINE_WORDS-1:0][WORD_W-1:0] line_t;

    // A value counts as a candidate address when nothing lies above the
    // virtual address width, it is non-null and it lies in [lo, hi).
    function automatic logic ptr_like(input logic [WORD_W-1:0] w,
                                      input int                va_w,
                                      input logic [WORD_W-1:0] lo,
                                      input logic [WORD_W-1:0] hi);
        logic upper_clear;
        upper_clear = ((w >> va_w) == '0);
        return upper_clear && (w != '0) && (w >= lo) && (w < hi);
    endfunction

endpackage

// File: rtl/dmp_hint_table.sv
`timescale 1ns/1ps
module dmp_hint_table #(
    parameter int N_LINES = 64,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_hint,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [N_LINES-1:0] hints
);

    logic [N_LINES-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else begin
            if (clr_en) bits_q[clr_idx] <= 1'b0;
            // set is applied last, so it wins a same-index collision
            if (set_en) bits_q[set_idx] <= 1'b1;
        end
    end

    assign rd_hint = bits_q[rd_idx];
    assign hints   = bits_q;

endmodule

// File: rtl/dmp_hist_filter.sv
`timescale 1ns/1ps
module dmp_hist_filter #(
    parameter int LA_W   = 42,
    parameter int HIST_N = 8,
    localparam int HB    = $clog2(HIST_N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LA_W-1:0] look_la,
    output logic            hit,
    input  logic            wr_en,
    input  logic [LA_W-1:0] wr_la
);

    logic [HIST_N-1:0]           vld_q;
    logic [HIST_N-1:0][LA_W-1:0] tag_q;
    logic [HB-1:0]               look_slot;
    logic [HB-1:0]               wr_slot;

    assign look_slot = look_la[HB-1:0];
    assign wr_slot   = wr_la[HB-1:0];
    assign hit       = vld_q[look_slot] && (tag_q[look_slot] == look_la);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            tag_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_slot] <= 1'b1;
            tag_q[wr_slot] <= wr_la;
        end
    end

endmodule

// File: rtl/dmp_req_fifo.sv
`timescale 1ns/1ps
module dmp_req_fifo #(
    parameter int W     = 48,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] dout
);

    logic [DEPTH-1:0][W-1:0] mem_q;
    logic [PW-1:0]           wr_q, rd_q;
    logic [CW-1:0]           cnt_q;
    logic                    pop;

    assign full      = (cnt_q == CW'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign dout      = mem_q[rd_q];
    assign pop       = out_valid && out_ready;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem_q[wr_q] <= din;
                wr_q        <= bump(wr_q);
            end
            if (pop) rd_q <= bump(rd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/dmp_prefetcher.sv
`timescale 1ns/1ps
module dmp_prefetcher #(
    parameter int          N_LINES  = 64,
    parameter int          VA_W     = 48,
    parameter logic [63:0] WIN_LO   = 64'h0000_0000_1000_0000,
    parameter logic [63:0] WIN_HI   = 64'h0000_7FFF_FFFF_F000,
    parameter int          HIST_N   = 8,
    parameter int          FIFO_D   = 4,
    parameter int          CNT_W    = 16,
    parameter logic [1:0]  SRC_MASK = 2'b11,
    localparam int         IDX_W    = $clog2(N_LINES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fill_valid,
    output logic                fill_ready,
    input  logic [IDX_W-1:0]    fill_idx,
    input  logic                fill_src,
    input  logic [511:0]        fill_data,
    input  logic                evict_valid,
    input  logic [IDX_W-1:0]    evict_idx,
    input  logic                evict_both,
    output logic                pf_valid,
    input  logic                pf_ready,
    output logic [VA_W-1:0]     pf_addr,
    output logic [CNT_W-1:0]    drop_cnt
);

    import dmp_pkg::*;

    localparam int LA_W = VA_W - OFF_W;
    localparam int WI_W = $clog2(LINE_WORDS);

    scan_st_e               state_q;
    logic [WI_W-1:0]        widx_q;
    line_t                  line_q;
    logic [LINE_WORDS-1:0]  mask_q;
    logic [LINE_WORDS-1:0]  ptr_vec;
    logic                   any_ptr, accept, src_ok, hinted, start;
    logic [WORD_W-1:0]      cur_word;
    logic [LA_W-1:0]        cur_la;
    logic                   hist_hit, cand, fifo_full, push, drop;
    logic [N_LINES-1:0]     hint_vec;

    // per-word candidate test on the incoming line
    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
        assign ptr_vec[g] = ptr_like(fill_data[g*WORD_W +: WORD_W], VA_W, WIN_LO, WIN_HI);
    end

    assign any_ptr    = |ptr_vec;
    assign fill_ready = (state_q == ST_IDLE);
    assign accept     = fill_valid && fill_ready;
    assign src_ok     = SRC_MASK[fill_src];
    assign start      = accept && src_ok && !hinted && any_ptr;

    dmp_hint_table #(.N_LINES(N_LINES)) u_hint (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (fill_idx),
        .rd_hint (hinted),
        .set_en  (start),
        .set_idx (fill_idx),
        .clr_en  (evict_valid && evict_both),
        .clr_idx (evict_idx),
        .hints   (hint_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            widx_q  <= '0;
            line_q  <= '0;
            mask_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        line_q  <= fill_data;
                        mask_q  <= ptr_vec;
                        widx_q  <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    widx_q <= widx_q + WI_W'(1);
                    if (widx_q == WI_W'(LINE_WORDS - 1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cur_word = line_q[widx_q];
    assign cur_la   = cur_word[VA_W-1:OFF_W];

    dmp_hist_filter #(.LA_W(LA_W), .HIST_N(HIST_N)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .look_la (cur_la),
        .hit     (hist_hit),
        .wr_en   (push),
        .wr_la   (cur_la)
    );

    assign cand = (state_q == ST_SCAN) && mask_q[widx_q] && !hist_hit;
    assign push = cand && !fifo_full;
    assign drop = cand && fifo_full;

    dmp_req_fifo #(.W(VA_W), .DEPTH(FIFO_D)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .din       ({cur_la, {OFF_W{1'b0}}}),
        .full      (fifo_full),
        .out_valid (pf_valid),
        .out_ready (pf_ready),
        .dout      (pf_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)                         drop_cnt <= '0;
        else if (drop && drop_cnt != '1) drop_cnt <= drop_cnt + CNT_W'(1);
    end

endmodule

// File: rtl/dmp_prefetcher_chk.sv
`timescale 1ns/1ps
module dmp_prefetcher_chk #(
    parameter int          N_LINES = 64,
    parameter int          VA_W    = 48,
    parameter logic [63:0] WIN_HI  = 64'h0000_7FFF_FFFF_F000,
    parameter int          CNT_W   = 16,
    localparam int         IDX_W   = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst,
    input logic               fill_valid,
    input logic               fill_ready,
    input logic [IDX_W-1:0]   fill_idx,
    input logic               evict_valid,
    input logic [IDX_W-1:0]   evict_idx,
    input logic               evict_both,
    input logic               pf_valid,
    input logic               pf_ready,
    input logic [VA_W-1:0]    pf_addr,
    input logic [CNT_W-1:0]   drop_cnt,
    input logic [N_LINES-1:0] hints
);

    logic [3:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)             low_run <= '0;
        else if (fill_ready) low_run <= '0;
        else if (low_run != 4'hF) low_run <= low_run + 4'd1;
    end

    p_busy_bound_r4: assert property (@(posedge clk) disable iff (rst)
        low_run <= 4'd8);

    p_busy_exact_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_ready && low_run != 4'd0) |-> low_run == 4'd8);

    p_hinted_skip_r5: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_ready && hints[fill_idx]) |=> fill_ready);

    p_start_marks_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(fill_ready) |-> hints[$past(fill_idx)]);

    p_evict_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_both && !(fill_valid && fill_ready && fill_idx == evict_idx))
        |=> !hints[$past(evict_idx)]);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> (pf_addr[5:0] == 6'd0 && {{(64-VA_W){1'b0}}, pf_addr} < WIN_HI));

    p_drop_step_r8: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + CNT_W'(1)));

endmodule

bind dmp_prefetcher dmp_prefetcher_chk #(
    .N_LINES (N_LINES),
    .VA_W    (VA_W),
    .WIN_HI  (WIN_HI),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fill_valid  (fill_valid),
    .fill_ready  (fill_ready),
    .fill_idx    (fill_idx),
    .evict_valid (evict_valid),
    .evict_idx   (evict_idx),
    .evict_both  (evict_both),
    .pf_valid    (pf_valid),
    .pf_ready    (pf_ready),
    .pf_addr     (pf_addr),
    .drop_cnt    (drop_cnt),
    .hints       (hint_vec)
);

// File: tb/test_dmp_prefetcher.sv
`timescale 1ns/1ps
module test_dmp_prefetcher;

    localparam int          NL = 64;
    localparam int          VA = 48;
    localparam logic [63:0] LO = 64'h0000_0000_1000_0000;
    localparam logic [63:0] HI = 64'h0000_7FFF_FFFF_F000;
    localparam int          HN = 8;
    localparam int          FD = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fill_valid = 1'b0;
    logic         fill_ready;
    logic [5:0]   fill_idx = '0;
    logic         fill_src = 1'b0;
    logic [511:0] fill_data = '0;
    logic         evict_valid = 1'b0;
    logic [5:0]   evict_idx = '0;
    logic         evict_both = 1'b0;
    logic         pf_valid;
    logic         pf_ready = 1'b1;
    logic [47:0]  pf_addr;
    logic [15:0]  drop_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dmp_prefetcher #(.N_LINES(NL), .VA_W(VA), .WIN_LO(LO), .WIN_HI(HI),
                     .HIST_N(HN), .FIFO_D(FD), .CNT_W(16), .SRC_MASK(2'b11)) i_dmp_prefetcher (
        .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_ready(fill_ready),
        .fill_idx(fill_idx), .fill_src(fill_src), .fill_data(fill_data),
        .evict_valid(evict_valid), .evict_idx(evict_idx), .evict_both(evict_both),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .drop_cnt(drop_cnt));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit           m_busy;
    int           m_w;
    logic [63:0]  m_line [8];
    bit           m_hint [NL];
    bit           m_hv   [HN];
    logic [41:0]  m_ht   [HN];
    logic [47:0]  m_q    [$];
    int           m_drop;
    bit           m_acc;
    logic [47:0]  got    [$];

    function automatic bit is_ptr(input logic [63:0] w);
        return (w[63:48] == 16'h0) && (w != 64'h0) && (w >= LO) && (w < HI);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_w = 0; m_drop = 0; m_acc = 0;
            m_q.delete();
            for (int i = 0; i < NL; i++) m_hint[i] = 0;
            for (int i = 0; i < HN; i++) begin m_hv[i] = 0; m_ht[i] = '0; end
        end else begin
            int  qs;
            bit  busy0;
            bit  any;
            bit  go;
            qs    = m_q.size();
            busy0 = m_busy;
            if (pf_valid && pf_ready) got.push_back(pf_addr);
            if (qs > 0 && pf_ready) void'(m_q.pop_front());
            if (busy0) begin
                if (is_ptr(m_line[m_w])) begin
                    logic [41:0] la;
                    int          s;
                    la = m_line[m_w][47:6];
                    s  = int'(la % HN);
                    if (!(m_hv[s] && m_ht[s] == la)) begin
                        if (qs == FD) begin
                            if (m_drop < 65535) m_drop++;
                        end else begin
                            m_q.push_back({la, 6'b0});
                            m_hv[s] = 1; m_ht[s] = la;
                        end
                    end
                end
                m_w++;
                if (m_w == 8) m_busy = 0;
            end
            m_acc = fill_valid && !busy0;
            any = 0;
            for (int k = 0; k < 8; k++) any |= is_ptr(fill_data[k*64 +: 64]);
            go = m_acc && !m_hint[fill_idx] && any;
            if (evict_valid && evict_both) m_hint[evict_idx] = 0;
            if (go) begin
                for (int k = 0; k < 8; k++) m_line[k] = fill_data[k*64 +: 64];
                m_busy = 1; m_w = 0;
                m_hint[fill_idx] = 1;
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(fill_ready == !m_busy, "R4 fill_ready", fill_ready, !m_busy);
            check(pf_valid == (m_q.size() > 0), "R9 pf_valid", pf_valid, m_q.size() > 0);
            if (pf_valid && m_q.size() > 0)
                check(pf_addr == m_q[0], "R3 pf_addr", pf_addr, m_q[0]);
            check(drop_cnt == m_drop[15:0], "R8 drop_cnt", drop_cnt, m_drop);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [511:0] pack8(input logic [63:0] a0, a1, a2, a3, a4, a5, a6, a7);
        return {a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (!fill_ready) @(negedge clk);
    endtask

    task automatic do_fill(input int idx, input bit src, input logic [511:0] d);
        wait_idle();
        fill_valid = 1; fill_idx = 6'(idx); fill_src = src; fill_data = d;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic do_evict(input int idx, input bit both);
        @(negedge clk);
        evict_valid = 1; evict_idx = 6'(idx); evict_both = both;
        @(negedge clk);
        evict_valid = 0; evict_both = 0;
    endtask

    function automatic logic [63:0] rnd_word();
        int r;
        r = int'($urandom % 6);
        case (r)
            0:       return 64'h0;
            1, 2:    return 64'h0000_5000_0000 + 64'(($urandom % 12) * 192) + 64'($urandom % 64);
            3:       return 64'h0000_6000_0000 + 64'(($urandom % 4096) * 8);
            4:       return 64'h0001_0000_0000_0000 | 64'($urandom);
            default: return 64'($urandom % 32'h1000_0000);
        endcase
    endfunction

    localparam logic [63:0] P1 = 64'h0000_2000_0040;
    localparam logic [63:0] P2 = 64'h0000_3000_1238;
    localparam logic [63:0] P3 = 64'h0000_4000_0080;
    localparam logic [63:0] P4 = 64'h0000_4100_0000;
    localparam logic [63:0] P5 = 64'h0000_4100_0200;

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: reset state
        check(fill_ready == 1'b1, "R10 fill_ready after reset", fill_ready, 1);
        check(pf_valid == 1'b0, "R10 pf_valid after reset", pf_valid, 0);
        check(drop_cnt == 16'h0, "R10 drop_cnt after reset", drop_cnt, 0);

        // R1/R2/R3: DRAM fill, only words 1 and 3 qualify
        base = got.size();
        do_fill(5, 1'b1, pack8(64'h0, P1, 64'h0001_0000_0000_0000, P2,
                               64'h0000_0FFF_FFC0, 64'h0, 64'h0, 64'h0));
        check(fill_ready == 1'b0, "R1 DRAM fill starts scan", fill_ready, 0);
        wait_idle(); repeat (4) @(negedge clk);
        check(got.size() == base + 2, "R2 candidate count", got.size() - base, 2);
        if (got.size() == base + 2) begin
            check(got[base] == P1[47:0], "R3 first request", got[base], P1);
            check(got[base+1] == 48'h0000_3000_1200, "R3 second request aligned", got[base+1], 48'h0000_3000_1200);
        end

        // R5: refill of a suppressed line does nothing
        base = got.size();
        do_fill(5, 1'b0, pack8(P3, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0));
        check(fill_ready == 1'b1, "R5 suppressed refill no scan", fill_ready, 1);
        repeat (12) @(negedge clk);
        check(got.size() == base, "R5 suppressed refill no request", got.size() - base, 0);

        // R6: single-level eviction ignored, both-level clears
        do_evict(5, 1'b0);
        do_fill(5, 1'b0, pack8(P3, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0));
        check(fill_ready == 1'b1, "R6 one-level eviction ignored", fill_ready, 1);
        do_evict(5, 1'b1);
        do_fill(5, 1'b0, pack8(P3, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0));
        check(fill_ready == 1'b0, "R6 both-level eviction re-arms (R1 L2 source)", fill_ready, 0);
        wait_idle(); repeat (4) @(negedge clk);

        // R7: history hit and slot replacement
        base = got.size();
        do_fill(9, 1'b1, pack8(P4, P4 + 8, P5, P4 + 16, 64'h0, 64'h0, 64'h0, 64'h0));
        wait_idle(); repeat (4) @(negedge clk);
        check(got.size() == base + 3, "R7 filtered count", got.size() - base, 3);
        if (got.size() == base + 3) begin
            check(got[base+1] == P5[47:0], "R7 colliding line issued", got[base+1], P5);
            check(got[base+2] == P4[47:0], "R7 replaced line reissued", got[base+2], P4);
        end

        // R8: overflow with stalled consumer
        base = got.size();
        pf_ready = 0;
        do_fill(12, 1'b1, pack8(64'h4200_0000, 64'h4200_0040, 64'h4200_0080, 64'h4200_00C0,
                                64'h4200_0100, 64'h4200_0140, 64'h4200_0180, 64'h4200_01C0));
        wait_idle();
        check(drop_cnt == 16'd4, "R8 four candidates discarded", drop_cnt, 4);
        check(pf_addr == 48'h4200_0000, "R9 head held under stall", pf_addr, 48'h4200_0000);
        pf_ready = 1;
        repeat (8) @(negedge clk);
        check(got.size() == base + 4, "R8 survivors drained", got.size() - base, 4);
        if (got.size() == base + 4)
            check(got[base+3] == 48'h4200_00C0, "R3 drain order", got[base+3], 48'h4200_00C0);

        // R11: scan start and both-level eviction on one index together
        wait_idle();
        fill_valid = 1; fill_idx = 6'd20; fill_src = 1'b1;
        fill_data = pack8(64'h4300_0000, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0);
        evict_valid = 1; evict_idx = 6'd20; evict_both = 1;
        @(negedge clk);
        fill_valid = 0; evict_valid = 0; evict_both = 0;
        do_fill(20, 1'b1, pack8(64'h4400_0000, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0));
        check(fill_ready == 1'b1, "R11 set wins over clear", fill_ready, 1);

        // mixed traffic against the model (R1..R9)
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            pf_ready = ($urandom % 4) != 0;
            if (fill_valid && m_acc) fill_valid = 0;
            if (!fill_valid && ($urandom % 3) == 0) begin
                fill_valid = 1;
                fill_idx   = 6'($urandom % 16);
                fill_src   = 1'($urandom);
                for (int k = 0; k < 8; k++) fill_data[k*64 +: 64] = rnd_word();
            end
            evict_valid = ($urandom % 4) == 0;
            evict_idx   = 6'($urandom % 16);
            evict_both  = 1'($urandom);
        end
        @(negedge clk);
        fill_valid = 0; evict_valid = 0; pf_ready = 1;
        repeat (20) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule